// File: doc/BRIEF.md
# Serial Receiver Status Flag Register

This block holds the error and status flags of a serial receiver and presents them as one 32-bit flags word. The receiver datapath sends it single-cycle strobes: a character move from the shift register into the receive buffer, which carries that character's stop-bit and parity results, and a read of the receive buffer. From these strobes the block keeps three error flags (framing, overrun, parity) and a receive-ready flag. Software clears the error flags in two ways: by writing ones to the flags word, or by reading the interrupt vector, which reports the code of the source being acknowledged. Active-low system reset, the software reset control and the module reset bit each force the receive-side flags to zero.

Each error flag has its own set of clear sources. The framing flag alone also tracks each new character: a well-framed arrival clears it and a badly framed one sets it. One error interrupt request is formed from the flags and a three-bit enable. The block carries no data stream, so every pin is a plain control or status level or strobe. There is no valid/ready handshake and no back-pressure. Every strobe is taken in the cycle it is high.

Top module: `rx_status_flags`

## Requirements
- R1: The flags word places framing error at bit 26, overrun at bit 25, parity error at bit 24, transmitter-empty at bit 11, receive-ready at bit 9 and transmitter-ready at bit 8. Every other bit reads 0, and no write changes it.
- R2: After system reset the word is 0x00000900: both transmitter bits are 1 and all other bits are 0.
- R3: A transfer strobe sets the framing flag when the first stop bit is bad. It also sets the flag when two stop bits are configured, compatibility mode is off, and the second stop bit is bad. In compatibility mode only the first stop bit is checked.
- R4: A transfer strobe sets receive-ready, and a buffer read clears it. A transfer that arrives while receive-ready is 1, with no buffer read in the same cycle, sets the overrun flag.
- R5: A transfer strobe whose character has a bad parity result sets the parity flag.
- R6: A write with a 1 in bit 26, 25 or 24 clears that error flag. A 0 in that bit leaves the flag unchanged.
- R7: A vector read clears one flag according to its code: code 7 clears framing, code 9 clears overrun and code 6 clears parity. Any other code changes nothing.
- R8: A transfer with good framing clears a framing flag left by an earlier character. Reception never clears the overrun or parity flag.
- R9: While software reset or module reset is high at a clock edge, all three error flags and receive-ready go to 0. This takes priority over any set event in that cycle.
- R10: If a set event and a write-one clear or a vector clear hit the same flag in the same cycle, the flag ends up set.
- R11: err_irq is high exactly while some error flag is 1 and its enable is 1. The enables map as irq_en[2] framing, [1] overrun and [0] parity. err_irq follows flag and enable changes in the same cycle, with no extra register.
- R12: Bits 8 and 11 show tx_rdy_in and tx_empty_in as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| sw_rst | input | 1 | Software reset control, clears receive flags while high |
| mod_rst | input | 1 | Module reset bit, clears receive flags while high |
| compat_mode | input | 1 | Compatibility mode, only the first stop bit is checked |
| two_stop | input | 1 | Two stop bits configured |
| rx_xfer | input | 1 | Strobe: character moved into the receive buffer |
| stop1_bad | input | 1 | First stop bit of the transferred character was 0 |
| stop2_bad | input | 1 | Second stop bit of the transferred character was 0 |
| parity_bad | input | 1 | Parity check of the transferred character failed |
| rx_buf_rd | input | 1 | Strobe: receive buffer read |
| wr_en | input | 1 | Bus write to the flags word |
| wr_data | input | 32 | Bus write data |
| vec_rd | input | 1 | Strobe: interrupt vector read |
| vec_code | input | 5 | Source code returned by that vector read |
| irq_en | input | 3 | Per-flag interrupt enables (framing, overrun, parity) |
| tx_rdy_in | input | 1 | Transmitter ready level |
| tx_empty_in | input | 1 | Transmitter empty level |
| flags_word | output | 32 | Flags word |
| err_irq | output | 1 | Error interrupt request |

## Verification
Every flag is a register, so a strobe that is high at edge N shows up in flags_word just after edge N. err_irq adds no register, so it changes in the same settled interval as the flag or enable that drives it. The bench drives each stimulus on the falling edge and holds it over one rising edge. It samples 1 ns after that rising edge, while the enables are still applied, and only then removes the strobes. Because that single delay applies to every result, cases where set and clear meet in one cycle (set wins, or reset wins) are judged in exactly the cycle the requirement names.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_ERR  = 3;
  localparam int unsigned CODE_W   = 5;

  // bit positions inside the flags word
  localparam int unsigned FE_POS   = 26;
  localparam int unsigned OE_POS   = 25;
  localparam int unsigned PE_POS   = 24;
  localparam int unsigned TXE_POS  = 11;
  localparam int unsigned RXR_POS  = 9;
  localparam int unsigned TXR_POS  = 8;

  // index of each error flag inside the error vector / enable vector
  localparam int unsigned IDX_PE   = 0;
  localparam int unsigned IDX_OE   = 1;
  localparam int unsigned IDX_FE   = 2;

  // vector-read source codes
  localparam logic [CODE_W-1:0] CODE_FE = 5'd7;
  localparam logic [CODE_W-1:0] CODE_OE = 5'd9;
  localparam logic [CODE_W-1:0] CODE_PE = 5'd6;

  typedef logic [NUM_ERR-1:0] err_vec_t;
endpackage

// File: rtl/rxf_flag_cell.sv
module rxf_flag_cell #(
  parameter bit AUTO_CLR = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hard_clr,
  input  logic set_ev,
  input  logic w1c,
  input  logic ack,
  input  logic rcv,
  output logic flag_o
);
  logic soft_clr;

  generate
    if (AUTO_CLR) begin : g_auto
      assign soft_clr = w1c | ack | rcv;
    end else begin : g_keep
      assign soft_clr = w1c | ack;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_o <= 1'b0;
    else if (hard_clr) flag_o <= 1'b0;
    else if (set_ev)   flag_o <= 1'b1;
    else if (soft_clr) flag_o <= 1'b0;
  end
endmodule

// File: rtl/rxf_rx_track.sv
module rxf_rx_track (
  input  logic clk,
  input  logic rst_n,
  input  logic hard_clr,
  input  logic compat_mode,
  input  logic two_stop,
  input  logic rx_xfer,
  input  logic stop1_bad,
  input  logic stop2_bad,
  input  logic parity_bad,
  input  logic rx_buf_rd,
  output logic rx_rdy_o,
  output logic fe_ev_o,
  output logic oe_ev_o,
  output logic pe_ev_o
);
  logic frame_bad;

  assign frame_bad = stop1_bad | (two_stop & ~compat_mode & stop2_bad);
  assign fe_ev_o   = rx_xfer & frame_bad;
  assign oe_ev_o   = rx_xfer & rx_rdy_o & ~rx_buf_rd;
  assign pe_ev_o   = rx_xfer & parity_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_rdy_o <= 1'b0;
    else if (hard_clr)  rx_rdy_o <= 1'b0;
    else if (rx_xfer)   rx_rdy_o <= 1'b1;
    else if (rx_buf_rd) rx_rdy_o <= 1'b0;
  end
endmodule

// File: rtl/rxf_irq_gen.sv
module rxf_irq_gen #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] en,
  output logic         irq
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = flags[i] & en[i];
  end

  assign irq = |hit;
endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              mod_rst,
  input  logic              compat_mode,
  input  logic              two_stop,
  input  logic              rx_xfer,
  input  logic              stop1_bad,
  input  logic              stop2_bad,
  input  logic              parity_bad,
  input  logic              rx_buf_rd,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              vec_rd,
  input  logic [CODE_W-1:0] vec_code,
  input  logic [NUM_ERR-1:0] irq_en,
  input  logic              tx_rdy_in,
  input  logic              tx_empty_in,
  output logic [WORD_W-1:0] flags_word,
  output logic              err_irq
);
  logic     hard_clr;
  logic     rx_rdy;
  err_vec_t set_ev, w1c, ack, err_q;
  logic     tx_rdy_q, tx_empty_q;

  assign hard_clr = sw_rst | mod_rst;

  rxf_rx_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .hard_clr   (hard_clr),
    .compat_mode(compat_mode),
    .two_stop   (two_stop),
    .rx_xfer    (rx_xfer),
    .stop1_bad  (stop1_bad),
    .stop2_bad  (stop2_bad),
    .parity_bad (parity_bad),
    .rx_buf_rd  (rx_buf_rd),
    .rx_rdy_o   (rx_rdy),
    .fe_ev_o    (set_ev[IDX_FE]),
    .oe_ev_o    (set_ev[IDX_OE]),
    .pe_ev_o    (set_ev[IDX_PE])
  );

  assign w1c[IDX_FE] = wr_en & wr_data[FE_POS];
  assign w1c[IDX_OE] = wr_en & wr_data[OE_POS];
  assign w1c[IDX_PE] = wr_en & wr_data[PE_POS];

  assign ack[IDX_FE] = vec_rd & (vec_code == CODE_FE);
  assign ack[IDX_OE] = vec_rd & (vec_code == CODE_OE);
  assign ack[IDX_PE] = vec_rd & (vec_code == CODE_PE);

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
    rxf_flag_cell #(.AUTO_CLR(i == IDX_FE)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .hard_clr(hard_clr),
      .set_ev  (set_ev[i]),
      .w1c     (w1c[i]),
      .ack     (ack[i]),
      .rcv     (rx_xfer),
      .flag_o  (err_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rdy_q   <= 1'b1;
      tx_empty_q <= 1'b1;
    end else begin
      tx_rdy_q   <= tx_rdy_in;
      tx_empty_q <= tx_empty_in;
    end
  end

  rxf_irq_gen #(.N(NUM_ERR)) u_irq (
    .flags(err_q),
    .en   (irq_en),
    .irq  (err_irq)
  );

  always_comb begin
    flags_word          = '0;
    flags_word[FE_POS]  = err_q[IDX_FE];
    flags_word[OE_POS]  = err_q[IDX_OE];
    flags_word[PE_POS]  = err_q[IDX_PE];
    flags_word[TXE_POS] = tx_empty_q;
    flags_word[RXR_POS] = rx_rdy;
    flags_word[TXR_POS] = tx_rdy_q;
  end
endmodule

// File: rtl/rx_status_flags_chk.sv
module rx_status_flags_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_rst,
  input logic        mod_rst,
  input logic        rx_xfer,
  input logic        stop1_bad,
  input logic        parity_bad,
  input logic        rx_buf_rd,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        vec_rd,
  input logic [4:0]  vec_code,
  input logic [2:0]  irq_en,
  input logic [31:0] flags_word,
  input logic        err_irq
);
  logic hard;
  assign hard = sw_rst | mod_rst;

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_word[31:27] == 5'd0) && (flags_word[23:12] == 12'd0) &&
    !flags_word[10] && (flags_word[7:0] == 8'd0)); // R1

  AST_FE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_xfer && stop1_bad && !hard) |=> flags_word[26]); // R3

  AST_OE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_xfer && flags_word[9] && !rx_buf_rd && !hard) |=> flags_word[25]); // R4

  AST_PE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_xfer && parity_bad && !hard) |=> flags_word[24]); // R5

  AST_OE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_word[25] && !hard && !(wr_en && wr_data[25]) &&
     !(vec_rd && vec_code == 5'd9)) |=> flags_word[25]); // R8

  AST_HARD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    hard |=> (flags_word[26:24] == 3'b000) && !flags_word[9]); // R9

  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> ((flags_word[26:24] & irq_en) != 3'b000)); // R11
endmodule

bind rx_status_flags rx_status_flags_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sw_rst    (sw_rst),
  .mod_rst   (mod_rst),
  .rx_xfer   (rx_xfer),
  .stop1_bad (stop1_bad),
  .parity_bad(parity_bad),
  .rx_buf_rd (rx_buf_rd),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .vec_rd    (vec_rd),
  .vec_code  (vec_code),
  .irq_en    (irq_en),
  .flags_word(flags_word),
  .err_irq   (err_irq)
);

// File: tb/sim_rx_status_flags.sv
module sim_rx_status_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_rst = 1'b0, mod_rst = 1'b0;
  logic        compat_mode = 1'b0, two_stop = 1'b0;
  logic        rx_xfer = 1'b0, stop1_bad = 1'b0, stop2_bad = 1'b0, parity_bad = 1'b0;
  logic        rx_buf_rd = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        vec_rd = 1'b0;
  logic [4:0]  vec_code = '0;
  logic [2:0]  irq_en = '0;
  logic        tx_rdy_in = 1'b1, tx_empty_in = 1'b1;
  logic [31:0] flags_word;
  logic        err_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rx_status_flags u0 (.*);

  typedef struct packed {
    logic       xf, s1, s2, two, cmp, par, brd, wr;
    logic [2:0] wd;     // write bits 26,25,24
    logic       vr;
    logic [4:0] code;
    logic [2:0] en;     // FE,OE,PE
    logic [2:0] e_err;  // expected FE,OE,PE
    logic       e_rdy;
    logic       e_irq;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    //  xf  s1  s2  two cmp par brd wr  wd      vr  code   en      err     rdy irq req
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,5'd0,3'b000,3'b000,1'b1,1'b0,4'd4},  // R4 ready
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,5'd0,3'b111,3'b110,1'b1,1'b1,4'd3},  // R3 + overrun
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,3'b000,1'b0,5'd0,3'b000,3'b110,1'b0,1'b0,4'd11}, // R11 masked
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'b000,1'b0,5'd0,3'b100,3'b011,1'b1,1'b0,4'd8},  // R8 FE auto clear, R5
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'b010,1'b0,5'd0,3'b001,3'b001,1'b1,1'b1,4'd6},  // R6 clear OE
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'b000,1'b0,5'd0,3'b000,3'b001,1'b1,1'b0,4'd6},  // R6 zero no effect
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b1,5'd9,3'b000,3'b001,1'b1,1'b0,4'd7},  // R7 OE code, OE clear
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b1,5'd6,3'b000,3'b000,1'b1,1'b0,4'd7},  // R7 PE code
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,3'b000,1'b0,5'd0,3'b100,3'b100,1'b1,1'b1,4'd3},  // R3 second stop, read same cycle
    '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,3'b000,1'b0,5'd0,3'b100,3'b000,1'b1,1'b0,4'd3},  // R3 compat ignores stop2
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'b110,1'b0,5'd0,3'b010,3'b110,1'b1,1'b1,4'd10}, // R10 set beats write
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b1,5'd7,3'b000,3'b010,1'b1,1'b0,4'd7},  // R7 FE code
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b1,5'd3,3'b010,3'b010,1'b1,1'b1,4'd7},  // R7 other code
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,5'd0,3'b000,3'b010,1'b1,1'b0,4'd8},  // R8 OE kept
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b1,5'd9,3'b000,3'b010,1'b1,1'b0,4'd10}, // R10 set beats ack
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'b111,1'b0,5'd0,3'b111,3'b000,1'b1,1'b0,4'd6},  // R6 clear all
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,3'b000,1'b0,5'd0,3'b000,3'b000,1'b0,1'b0,4'd4}   // R4 read clears ready
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rx_xfer = 0; stop1_bad = 0; stop2_bad = 0; parity_bad = 0; rx_buf_rd = 0;
    wr_en = 0; wr_data = '0; vec_rd = 0; vec_code = '0;
    two_stop = 0; compat_mode = 0; sw_rst = 0; mod_rst = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset word", flags_word, 32'h0000_0900);
    check("R11 irq at reset", {31'd0, err_irq}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rx_xfer = TBL[i].xf; stop1_bad = TBL[i].s1; stop2_bad = TBL[i].s2;
      two_stop = TBL[i].two; compat_mode = TBL[i].cmp; parity_bad = TBL[i].par;
      rx_buf_rd = TBL[i].brd; wr_en = TBL[i].wr;
      wr_data = {5'd0, TBL[i].wd, 24'd0};
      vec_rd = TBL[i].vr; vec_code = TBL[i].code; irq_en = TBL[i].en;
      step();
      check($sformatf("R%0d vec %0d err", TBL[i].req, i), {29'd0, flags_word[26:24]}, {29'd0, TBL[i].e_err});
      check($sformatf("R%0d vec %0d rdy", TBL[i].req, i), {31'd0, flags_word[9]}, {31'd0, TBL[i].e_rdy});
      check($sformatf("R%0d vec %0d irq", TBL[i].req, i), {31'd0, err_irq}, {31'd0, TBL[i].e_irq});
    end
    @(negedge clk); idle_inputs(); irq_en = 3'b000;

    // R1: write all ones: reserved bits stay zero, tx bits untouched
    @(negedge clk); wr_en = 1; wr_data = 32'hFFFF_FFFF;
    step();
    check("R1 write all ones", flags_word, 32'h0000_0900);
    @(negedge clk); idle_inputs();

    // R12: tx bits follow inputs one edge later
    @(negedge clk); tx_rdy_in = 0; tx_empty_in = 0;
    #1 check("R12 before edge", flags_word, 32'h0000_0900);
    step();
    check("R12 after edge", flags_word, 32'h0000_0000);
    @(negedge clk); tx_rdy_in = 1;
    step();
    check("R12 ready back", flags_word, 32'h0000_0100);

    // R5 parity alone + R11 enable
    @(negedge clk); rx_xfer = 1; parity_bad = 1; irq_en = 3'b001;
    step();
    check("R5 parity set", flags_word, 32'h0100_0300);
    check("R11 parity irq", {31'd0, err_irq}, 32'd1);
    @(negedge clk); idle_inputs();
    irq_en = 3'b110;
    #1 check("R11 enable removed", {31'd0, err_irq}, 32'd0);

    // R9: software reset beats set events
    @(negedge clk); rx_xfer = 1; stop1_bad = 1; sw_rst = 1;
    step();
    check("R9 sw reset wins", flags_word, 32'h0000_0100);
    @(negedge clk); idle_inputs();
    rx_xfer = 1; stop1_bad = 1;
    step();
    @(negedge clk); idle_inputs(); rx_xfer = 1; parity_bad = 1; stop1_bad = 1;
    step();
    check("R9 setup flags", flags_word, 32'h0700_0300);
    @(negedge clk); idle_inputs(); mod_rst = 1;
    step();
    check("R9 module reset", flags_word, 32'h0000_0100);
    @(negedge clk); idle_inputs(); irq_en = 3'b000;

    // R2: system reset mid-run
    @(negedge clk); rx_xfer = 1; stop1_bad = 1;
    step();
    @(negedge clk); idle_inputs(); rst_n = 0; tx_empty_in = 1;
    #1 check("R2 async reset", flags_word, 32'h0000_0900);
    @(negedge clk); rst_n = 1;
    step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule